// File: doc/BRIEF.md
# UART Boot Download Engine

This block loads a code image into on-chip RAM over a plain serial line when a chip has nothing to run yet. It leaves reset and at once sends a start byte. It then waits for the host to answer with a start-of-header byte and a two-byte length. After that it takes in the stated number of payload bytes and writes each one into RAM through a byte-write port. It packs the bytes little-endian into 32-bit words, starting at word address zero.

Once the payload is complete, the engine sends back a one-byte XOR checksum of the payload. The host must then confirm with an acknowledge byte. Only then does the engine report success and pulse its two requests: one to map address zero onto RAM, and one for a software reset. Every wait for a host byte is bounded by a programmable number of clock cycles. When a wait runs out, or the host sends a wrong byte, the engine stops with a failure.

The serial line uses 8 data bits, no parity and one stop bit. A fixed number of clock cycles per bit is set at build time. The transmitter, the receiver and the gap timer are separate submodules under the protocol controller.

Top module: `uart_boot_loader`

## Requirements
- R1: While reset is held, the serial output is high, `done_o` is low and no RAM write occurs. The first frame sent after reset is released carries the byte 0x02.
- R2: Every frame in both directions is a low start bit, 8 data bits least significant bit first, no parity and a high stop bit. Each bit lasts CLKS_PER_BIT clock cycles.
- R3: Three host bytes may follow the start byte: 0x01, then the length low byte, then the length high byte. The length is a count of payload bytes. The engine answers these with 0x06.
- R4: If the first of the three header bytes is not 0x01, the engine answers 0x15 and ends in failure. It performs no RAM write and accepts no payload.
- R5: While the engine waits for a host byte, a gap of more than `timeout_i` clock cycles ends the boot in failure. A gap before any header byte sends nothing. A gap after one or two header bytes sends 0x15 first. A gap inside the payload sends nothing.
- R6: Payload byte number k (counting from 0) causes exactly one write. That write has word address k/4 and a byte enable with only bit k mod 4 set. The byte sits in lane k mod 4, which is bits 8*(k mod 4)+7 down to 8*(k mod 4) of `ram_wdata_o`. No other writes occur.
- R7: After the last payload byte, the engine sends the XOR of all payload bytes, starting from 0x00. With a length of zero it sends 0x00 straight after the 0x06.
- R8: If the host answers the checksum with 0x06, the engine raises `done_o` and `pass_o`. In the same single cycle it pulses `remap_req_o` and `soft_rst_req_o` once each.
- R9: Any other byte after the checksum, or a timeout there, ends in failure: `done_o` high, `pass_o` low, and no remap or reset pulse.
- R10: Once `done_o` is high, it and `pass_o` hold until reset. The serial output stays idle, no RAM write occurs, and further host bytes have no effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rx_i | input | 1 | Serial data from the host (asynchronous, synchronised inside) |
| tx_o | output | 1 | Serial data to the host, idle high |
| timeout_i | input | TMO_W | Longest allowed gap, in clock cycles, while waiting for a host byte |
| ram_we_o | output | 1 | One-cycle RAM byte-write strobe |
| ram_addr_o | output | ADDR_W | RAM word address |
| ram_wdata_o | output | 32 | Write data, with the byte placed in its lane |
| ram_be_o | output | 4 | Byte enable, one bit set per write |
| done_o | output | 1 | Boot finished (success or failure) |
| pass_o | output | 1 | Boot finished with host confirmation |
| remap_req_o | output | 1 | One-cycle request to map address zero to RAM |
| soft_rst_req_o | output | 1 | One-cycle software reset request |

## Verification
A controller that loses its place in the exchange shows up at the next byte it sends. That byte is a wrong reply, a checksum that disagrees with the bench's XOR, or a byte sent when none is due. Each of these can be seen within one frame time of the host byte that should have caused it. A wrong byte counter or lane decode shows up in the RAM model captured from the write port, where words land at shifted addresses or with wrong enables. The bench also checks bytes it wrote a marker value to and expects to stay untouched. A broken gap timer either ends a healthy exchange early or lets a silent host hang the engine past timeout plus a small margin. Each bench silence test looks for exactly that.

// File: rtl/ubl_pkg.sv
// Shared constants and the controller state type for the UART boot engine.
// Assumes 8-bit characters and a 32-bit RAM word.
package ubl_pkg;
    localparam logic [7:0] CH_STX = 8'h02;
    localparam logic [7:0] CH_SOH = 8'h01;
    localparam logic [7:0] CH_ACK = 8'h06;
    localparam logic [7:0] CH_NAK = 8'h15;

    localparam int LEN_BITS   = 16;
    localparam int WORD_BYTES = 4;
    localparam int LANE_BITS  = $clog2(WORD_BYTES);
    localparam int WORD_BITS  = 8 * WORD_BYTES;

    typedef enum logic [2:0] {
        ST_TX,
        ST_TX_WAIT,
        ST_HDR,
        ST_DATA,
        ST_SEND_SUM,
        ST_CONFIRM,
        ST_PASS,
        ST_FAIL
    } boot_state_t;
endpackage

// File: rtl/ubl_uart_tx.sv
// Serialiser: sends one 8N1 character per accepted byte, LSB first.
// Assumes CLKS_PER_BIT >= 2; tx_o idles high and ready_o is high when idle.
module ubl_uart_tx #(
    parameter int CLKS_PER_BIT = 139
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [7:0] data_i,
    input  logic       valid_i,
    output logic       ready_o,
    output logic       tx_o
);
    localparam int CW = $clog2(CLKS_PER_BIT);

    logic          busy_q;
    logic          line_q;
    logic [8:0]    shreg_q;
    logic [3:0]    bits_left_q;
    logic [CW-1:0] tick_q;

    // Walk start bit, data bits and stop bit, each lasting one bit period.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            busy_q      <= 1'b0;
            line_q      <= 1'b1;
            shreg_q     <= '1;
            bits_left_q <= '0;
            tick_q      <= '0;
        end else if (!busy_q) begin
            if (valid_i) begin
                busy_q      <= 1'b1;
                line_q      <= 1'b0;
                shreg_q     <= {1'b1, data_i};
                bits_left_q <= 4'd9;
                tick_q      <= CW'(CLKS_PER_BIT - 1);
            end
        end else if (tick_q != '0) begin
            tick_q <= tick_q - 1'b1;
        end else if (bits_left_q == 4'd0) begin
            busy_q <= 1'b0;
        end else begin
            line_q      <= shreg_q[0];
            shreg_q     <= {1'b1, shreg_q[8:1]};
            bits_left_q <= bits_left_q - 1'b1;
            tick_q      <= CW'(CLKS_PER_BIT - 1);
        end
    end

    assign ready_o = !busy_q;
    assign tx_o    = line_q;

    AST_TX_IDLE_HIGH: assert property (@(posedge clk) disable iff (!rst_n)
        !busy_q |-> line_q); // R2
endmodule

// File: rtl/ubl_uart_rx.sv
// Deserialiser: finds a start bit, samples each bit at its centre and
// presents the byte for one cycle near the end of a valid stop bit.
// Assumes CLKS_PER_BIT >= 4; frames with a low stop bit are dropped.
module ubl_uart_rx #(
    parameter int CLKS_PER_BIT = 139
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       rx_i,
    output logic [7:0] data_o,
    output logic       valid_o
);
    localparam int CW   = $clog2(CLKS_PER_BIT);
    localparam int HALF = CLKS_PER_BIT / 2;
    localparam int TAIL = (HALF > 2) ? HALF - 2 : 0;

    typedef enum logic [2:0] {RX_IDLE, RX_START, RX_BITS, RX_STOP, RX_TAIL} rx_state_t;

    rx_state_t     st_q;
    logic [1:0]    sync_q;
    logic [7:0]    shreg_q;
    logic [2:0]    idx_q;
    logic [CW-1:0] tick_q;
    logic          valid_q;
    logic          rxs;

    // Two-stage synchroniser for the asynchronous line.
    always_ff @(posedge clk) begin
        if (!rst_n) sync_q <= 2'b11;
        else        sync_q <= {sync_q[0], rx_i};
    end
    assign rxs = sync_q[1];

    // Bit-timing state machine.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q    <= RX_IDLE;
            shreg_q <= '0;
            idx_q   <= '0;
            tick_q  <= '0;
            valid_q <= 1'b0;
        end else begin
            valid_q <= 1'b0;
            unique case (st_q)
                RX_IDLE: if (!rxs) begin
                    tick_q <= CW'(HALF - 1);
                    st_q   <= RX_START;
                end
                RX_START: if (tick_q != '0) tick_q <= tick_q - 1'b1;
                    else if (!rxs) begin
                        tick_q <= CW'(CLKS_PER_BIT - 1);
                        idx_q  <= '0;
                        st_q   <= RX_BITS;
                    end else st_q <= RX_IDLE;
                RX_BITS: if (tick_q != '0) tick_q <= tick_q - 1'b1;
                    else begin
                        shreg_q <= {rxs, shreg_q[7:1]};
                        tick_q  <= CW'(CLKS_PER_BIT - 1);
                        idx_q   <= idx_q + 1'b1;
                        if (idx_q == 3'd7) st_q <= RX_STOP;
                    end
                RX_STOP: if (tick_q != '0) tick_q <= tick_q - 1'b1;
                    else if (rxs) begin
                        tick_q <= CW'(TAIL);
                        st_q   <= RX_TAIL;
                    end else st_q <= RX_IDLE;
                RX_TAIL: if (tick_q != '0) tick_q <= tick_q - 1'b1;
                    else begin
                        valid_q <= 1'b1;
                        st_q    <= RX_IDLE;
                    end
                default: st_q <= RX_IDLE;
            endcase
        end
    end

    assign data_o  = shreg_q;
    assign valid_o = valid_q;

    AST_RX_VALID_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        valid_q |=> !valid_q); // R2
endmodule

// File: rtl/ubl_gap_timer.sv
// Counts idle cycles while the controller waits for a host byte.
// Assumes clear_i is held whenever run_i is low; expiry is level, not latched.
module ubl_gap_timer #(
    parameter int TMO_W = 20
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clear_i,
    input  logic             run_i,
    input  logic [TMO_W-1:0] limit_i,
    output logic             expired_o
);
    logic [TMO_W-1:0] cnt_q;

    // Saturating count of cycles since the last clear.
    always_ff @(posedge clk) begin
        if (!rst_n || clear_i)            cnt_q <= '0;
        else if (run_i && cnt_q < limit_i) cnt_q <= cnt_q + 1'b1;
    end

    assign expired_o = run_i && !clear_i && (cnt_q >= limit_i);
endmodule

// File: rtl/uart_boot_loader.sv
// Boot download controller: sends STX, reads SOH and length, stores the
// payload into RAM word-packed, returns an XOR checksum and waits for the
// host's final acknowledge before requesting remap and software reset.
// Assumes a byte-write RAM port that accepts one write per cycle.
module uart_boot_loader
    import ubl_pkg::*;
#(
    parameter int CLKS_PER_BIT = 139,
    parameter int ADDR_W       = 13,
    parameter int TMO_W        = 20
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 rx_i,
    output logic                 tx_o,
    input  logic [TMO_W-1:0]     timeout_i,
    output logic                 ram_we_o,
    output logic [ADDR_W-1:0]    ram_addr_o,
    output logic [WORD_BITS-1:0] ram_wdata_o,
    output logic [WORD_BYTES-1:0] ram_be_o,
    output logic                 done_o,
    output logic                 pass_o,
    output logic                 remap_req_o,
    output logic                 soft_rst_req_o
);
    boot_state_t          state_q, ret_q;
    logic [7:0]           tx_byte_q;
    logic [1:0]           hdr_cnt_q;
    logic                 soh_ok_q;
    logic [LEN_BITS-1:0]  len_q;
    logic [LEN_BITS-1:0]  byte_cnt_q;
    logic [7:0]           sum_q;
    logic                 we_q;
    logic [ADDR_W-1:0]    addr_q;
    logic [WORD_BITS-1:0] wdata_q;
    logic [WORD_BYTES-1:0] be_q;
    logic                 req_q;

    logic                 tx_ready;
    logic [7:0]           rx_byte;
    logic                 rx_valid;
    logic                 tmo_run, tmo_clr, tmo_hit;
    logic [WORD_BYTES-1:0] lane_sel;
    logic [LEN_BITS-1:0]  len_next;

    ubl_uart_tx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_tx (
        .clk     (clk),
        .rst_n   (rst_n),
        .data_i  (tx_byte_q),
        .valid_i (state_q == ST_TX),
        .ready_o (tx_ready),
        .tx_o    (tx_o)
    );

    ubl_uart_rx #(.CLKS_PER_BIT(CLKS_PER_BIT)) u_rx (
        .clk     (clk),
        .rst_n   (rst_n),
        .rx_i    (rx_i),
        .data_o  (rx_byte),
        .valid_o (rx_valid)
    );

    assign tmo_run = (state_q == ST_HDR) || (state_q == ST_DATA) || (state_q == ST_CONFIRM);
    assign tmo_clr = !tmo_run || rx_valid;

    ubl_gap_timer #(.TMO_W(TMO_W)) u_gap (
        .clk       (clk),
        .rst_n     (rst_n),
        .clear_i   (tmo_clr),
        .run_i     (tmo_run),
        .limit_i   (timeout_i),
        .expired_o (tmo_hit)
    );

    // Byte-lane decode of the running byte counter.
    for (genvar g = 0; g < WORD_BYTES; g++) begin : g_lane
        assign lane_sel[g] = (byte_cnt_q[LANE_BITS-1:0] == LANE_BITS'(g));
    end

    assign len_next = {rx_byte, len_q[7:0]};

    // Protocol sequencer: handshake, payload storage, checksum, confirmation.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q    <= ST_TX;
            ret_q      <= ST_HDR;
            tx_byte_q  <= CH_STX;
            hdr_cnt_q  <= '0;
            soh_ok_q   <= 1'b0;
            len_q      <= '0;
            byte_cnt_q <= '0;
            sum_q      <= '0;
            we_q       <= 1'b0;
            addr_q     <= '0;
            wdata_q    <= '0;
            be_q       <= '0;
            req_q      <= 1'b0;
        end else begin
            we_q  <= 1'b0;
            req_q <= 1'b0;
            unique case (state_q)
                ST_TX:      if (tx_ready) state_q <= ST_TX_WAIT;
                ST_TX_WAIT: if (tx_ready) state_q <= ret_q;
                ST_HDR: begin
                    if (rx_valid) begin
                        hdr_cnt_q <= hdr_cnt_q + 1'b1;
                        unique case (hdr_cnt_q)
                            2'd0: soh_ok_q <= (rx_byte == CH_SOH);
                            2'd1: len_q[7:0] <= rx_byte;
                            default: begin
                                len_q     <= len_next;
                                tx_byte_q <= soh_ok_q ? CH_ACK : CH_NAK;
                                state_q   <= ST_TX;
                                if (!soh_ok_q)           ret_q <= ST_FAIL;
                                else if (len_next == '0) ret_q <= ST_SEND_SUM;
                                else                     ret_q <= ST_DATA;
                            end
                        endcase
                    end else if (tmo_hit) begin
                        if (hdr_cnt_q == 2'd0) state_q <= ST_FAIL;
                        else begin
                            tx_byte_q <= CH_NAK;
                            ret_q     <= ST_FAIL;
                            state_q   <= ST_TX;
                        end
                    end
                end
                ST_DATA: begin
                    if (rx_valid) begin
                        we_q       <= 1'b1;
                        addr_q     <= ADDR_W'(byte_cnt_q >> LANE_BITS);
                        wdata_q    <= {WORD_BYTES{rx_byte}};
                        be_q       <= lane_sel;
                        sum_q      <= sum_q ^ rx_byte;
                        byte_cnt_q <= byte_cnt_q + 1'b1;
                        if (byte_cnt_q == len_q - 1'b1) state_q <= ST_SEND_SUM;
                    end else if (tmo_hit) begin
                        state_q <= ST_FAIL;
                    end
                end
                ST_SEND_SUM: begin
                    tx_byte_q <= sum_q;
                    ret_q     <= ST_CONFIRM;
                    state_q   <= ST_TX;
                end
                ST_CONFIRM: begin
                    if (rx_valid) begin
                        if (rx_byte == CH_ACK) begin
                            state_q <= ST_PASS;
                            req_q   <= 1'b1;
                        end else begin
                            state_q <= ST_FAIL;
                        end
                    end else if (tmo_hit) begin
                        state_q <= ST_FAIL;
                    end
                end
                ST_PASS: state_q <= ST_PASS;
                ST_FAIL: state_q <= ST_FAIL;
                default: state_q <= ST_FAIL;
            endcase
        end
    end

    assign ram_we_o       = we_q;
    assign ram_addr_o     = addr_q;
    assign ram_wdata_o    = wdata_q;
    assign ram_be_o       = be_q;
    assign done_o         = (state_q == ST_PASS) || (state_q == ST_FAIL);
    assign pass_o         = (state_q == ST_PASS);
    assign remap_req_o    = req_q;
    assign soft_rst_req_o = req_q;

    AST_BE_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        ram_we_o |-> $countones(ram_be_o) == 1); // R6
    AST_REQ_ON_PASS: assert property (@(posedge clk) disable iff (!rst_n)
        remap_req_o |-> done_o && pass_o); // R8
    AST_REQ_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
        remap_req_o |=> !remap_req_o); // R8
    AST_DONE_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |=> done_o && $stable(pass_o)); // R10
    AST_QUIET_AFTER_DONE: assert property (@(posedge clk) disable iff (!rst_n)
        done_o |-> tx_o && !ram_we_o); // R10
endmodule

// File: tb/uart_boot_loader_bench.sv
module uart_boot_loader_bench;
    localparam int CPB = 8;
    localparam int TMO = 1500;
    localparam int NW  = 16;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        rx = 1'b1;
    logic        tx;
    logic        ram_we;
    logic [3:0]  ram_addr;
    logic [31:0] ram_wdata;
    logic [3:0]  ram_be;
    logic        done, pass, remap, srst;

    int n_tests = 0;
    int n_fail  = 0;

    logic [31:0] mem [NW];
    int wr_cnt, req_cnt, srst_cnt, pair_err;

    always #10 clk = ~clk;

    uart_boot_loader #(.CLKS_PER_BIT(CPB), .ADDR_W(4), .TMO_W(20)) u_uart_boot_loader (
        .clk(clk), .rst_n(rst_n), .rx_i(rx), .tx_o(tx), .timeout_i(20'(TMO)),
        .ram_we_o(ram_we), .ram_addr_o(ram_addr), .ram_wdata_o(ram_wdata), .ram_be_o(ram_be),
        .done_o(done), .pass_o(pass), .remap_req_o(remap), .soft_rst_req_o(srst)
    );

    // RAM model and request monitor, observed away from the active edge.
    always @(negedge clk) begin
        if (!rst_n) begin
            for (int i = 0; i < NW; i++) mem[i] = 32'hA5A5A5A5;
            wr_cnt = 0; req_cnt = 0; srst_cnt = 0; pair_err = 0;
        end else begin
            if (ram_we) begin
                wr_cnt++;
                for (int b = 0; b < 4; b++)
                    if (ram_be[b]) mem[ram_addr][b*8 +: 8] = ram_wdata[b*8 +: 8];
            end
            if (remap) req_cnt++;
            if (srst) srst_cnt++;
            if (remap != srst) pair_err++;
        end
    end

    initial begin
        repeat (200000) @(posedge clk);
        $display("FAIL watchdog expired actual=hung expected=finished");
        $display("[TB] %0d tests run, %0d failed", n_tests + 1, n_fail + 1);
        $finish;
    end

    task automatic check(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_tests++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [7:0] pat(input int seed, input int k);
        return 8'((k * 29 + seed * 53 + 7) & 255);
    endfunction

    task automatic do_reset();
        rst_n = 1'b0;
        rx = 1'b1;
        repeat (5) @(negedge clk);
        rst_n = 1'b1;
    endtask

    task automatic send(input logic [7:0] b);
        rx = 1'b0;
        repeat (CPB) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            rx = b[i];
            repeat (CPB) @(negedge clk);
        end
        rx = 1'b1;
        repeat (CPB) @(negedge clk);
    endtask

    task automatic recv(output bit got, output logic [7:0] b, input int maxw);
        got = 1'b0;
        b = 8'h00;
        for (int i = 0; i < maxw && tx !== 1'b0; i++) @(negedge clk);
        if (tx !== 1'b0) return;
        repeat (CPB / 2) @(negedge clk);
        for (int i = 0; i < 8; i++) begin
            repeat (CPB) @(negedge clk);
            b[i] = tx;
        end
        repeat (CPB) @(negedge clk);
        check(tx === 1'b1, "R2 stop bit", 32'(tx), 32'h1);
        got = 1'b1;
    endtask

    task automatic expect_byte(input logic [7:0] exp, input string tag);
        bit got;
        logic [7:0] b;
        recv(got, b, 40 * CPB);
        check(got && b == exp, tag, got ? 32'(b) : 32'hFFFF, 32'(exp));
    endtask

    // Stimulus table: {length, first header byte, final host reply, expect pass}.
    localparam int NV = 7;
    localparam logic [32:0] VECS [NV] = '{
        {16'd8,  8'h01, 8'h06, 1'b1},
        {16'd5,  8'h01, 8'h06, 1'b1},
        {16'd0,  8'h01, 8'h06, 1'b1},
        {16'd3,  8'h01, 8'h15, 1'b0},
        {16'd4,  8'h7E, 8'h06, 1'b0},
        {16'd1,  8'h01, 8'h00, 1'b0},
        {16'd12, 8'h01, 8'h06, 1'b1}
    };

    task automatic run_vec(input int seed, input logic [32:0] v);
        int len;
        logic [7:0] first, fin, csum, eb;
        bit exp_pass;
        logic [31:0] ew;
        len = int'(v[32:17]);
        first = v[16:9];
        fin = v[8:1];
        exp_pass = v[0];
        do_reset();
        expect_byte(8'h02, "R1 start byte");
        send(first);
        send(v[24:17]);
        send(v[32:25]);
        if (first != 8'h01) begin
            expect_byte(8'h15, "R4 header NACK");
            repeat (50) @(negedge clk);
            check(done && !pass, "R4 failure", {done, pass}, 32'h2);
            check(wr_cnt == 0, "R4 no write", wr_cnt, 0);
            return;
        end
        expect_byte(8'h06, "R3 header ACK");
        csum = 8'h00;
        for (int k = 0; k < len; k++) begin
            send(pat(seed, k));
            csum ^= pat(seed, k);
        end
        expect_byte(csum, "R7 checksum");
        send(fin);
        repeat (40) @(negedge clk);
        check(done && (pass == exp_pass), exp_pass ? "R8 pass" : "R9 fail",
              {done, pass}, {1'b1, exp_pass});
        check(req_cnt == (exp_pass ? 1 : 0) && srst_cnt == req_cnt && pair_err == 0,
              exp_pass ? "R8 request pulses" : "R9 no requests", req_cnt, exp_pass ? 1 : 0);
        check(wr_cnt == len, "R6 write count", wr_cnt, len);
        for (int w = 0; w < NW; w++) begin
            ew = 32'hA5A5A5A5;
            for (int b = 0; b < 4; b++) begin
                eb = (w * 4 + b < len) ? pat(seed, w * 4 + b) : 8'hA5;
                ew[b*8 +: 8] = eb;
            end
            check(mem[w] == ew, "R6 RAM word", mem[w], ew);
        end
    endtask

    initial begin
        bit got;
        logic [7:0] b;

        // Reset state.
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        check(tx === 1'b1 && !done && !ram_we && !remap, "R1 reset state",
              {tx, done, ram_we, remap}, 32'h8);

        for (int i = 0; i < NV; i++) run_vec(i + 1, VECS[i]);

        // Silence after start byte: no reply, failure.
        do_reset();
        expect_byte(8'h02, "R1 start byte");
        recv(got, b, TMO + 400);
        check(!got, "R5 silent host gets no reply", 32'(got), 0);
        check(done && !pass, "R5 fail after silence", {done, pass}, 32'h2);

        // Partial header then silence: NACK, failure.
        do_reset();
        expect_byte(8'h02, "R1 start byte");
        send(8'h01);
        recv(got, b, TMO + 400);
        check(got && b == 8'h15, "R5 partial header NACK", 32'(b), 32'h15);
        repeat (40) @(negedge clk);
        check(done && !pass, "R5 partial header fail", {done, pass}, 32'h2);

        // Payload timeout.
        do_reset();
        expect_byte(8'h02, "R1 start byte");
        send(8'h01); send(8'h04); send(8'h00);
        expect_byte(8'h06, "R3 header ACK");
        send(8'h11); send(8'h22);
        repeat (TMO + 400) @(negedge clk);
        check(done && !pass && wr_cnt == 2 && req_cnt == 0, "R5 payload timeout",
              {done, pass, 30'(wr_cnt)}, 32'h80000002);

        // Confirmation timeout.
        do_reset();
        expect_byte(8'h02, "R1 start byte");
        send(8'h01); send(8'h02); send(8'h00);
        expect_byte(8'h06, "R3 header ACK");
        send(8'h3C); send(8'h5A);
        expect_byte(8'h66, "R7 checksum two bytes");
        repeat (TMO + 400) @(negedge clk);
        check(done && !pass && req_cnt == 0, "R9 confirm timeout",
              {done, pass, 30'(req_cnt)}, 32'h80000000);

        // Host bytes after a finished boot have no effect.
        run_vec(9, {16'd1, 8'h01, 8'h06, 1'b1});
        send(8'h01);
        recv(got, b, 300);
        check(!got, "R10 no reply after done", 32'(got), 0);
        check(done && pass && wr_cnt == 1 && req_cnt == 1, "R10 state held",
              {done, pass, 30'(wr_cnt)}, 32'hC0000001);

        $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
        $finish;
    end
endmodule